// File: doc/BRIEF.md
# Byte-Serial Instruction Field Parser

This block takes an x86 instruction stream one byte at a time and tracks where each byte falls in the instruction format. It starts with any number of prefix bytes, then takes the opcode, an optional ModR/M byte and an optional SIB byte, and ends with the displacement and immediate bytes. The instruction length is worked out as the bytes arrive. Prefixes set the operand size and the address size. The ModR/M and SIB addressing modes then decide whether more bytes follow and how many. The opcode alone does not fix the length.

The parser recognises only a small set of opcodes, held in a parameter table. Each table entry says whether the opcode takes a ModR/M byte and what kind of immediate it carries. A done strobe marks the last byte of each instruction. In that same cycle the parser shows the total length, the prefix flags, the segment override and the ModR/M fields. Opcodes outside the table raise an error. The default table holds the byte and word/dword forms of store-immediate (0xC6, 0xC7) and the register/memory move forms 0x88 to 0x8B.

Top module: `x86_field_parser`

## Requirements
- R1: A synchronous active-low reset puts the parser in the prefix state. After reset, done_o and err_o are low, and all prefix flags and seg_o read zero.
- R2: Each prefix byte adds one to the length and sets a flag. The prefix bytes and their flags are: 0x66 sets op16_o, 0x67 sets addr_ovr_o, 0xF0 sets lock_o, 0xF2 sets repne_o and 0xF3 sets rep_o. A 0x66 prefix does not change the 1-byte immediate of opcode 0xC6.
- R3: seg_o reports the segment override. The prefix bytes and their codes are: 0x26 gives 1, 0x2E gives 2, 0x36 gives 3, 0x3E gives 4, 0x64 gives 5 and 0x65 gives 6. With no override, seg_o is 0. When several segment prefixes appear, the last one sets the code.
- R4: With mode64_i high, prefix bytes 0x26, 0x2E, 0x36 and 0x3E still count toward the length but leave seg_o unchanged. Prefix bytes 0x64 and 0x65 still take effect.
- R5: Opcode 0xC6 carries a 1-byte immediate. Opcode 0xC7 carries a 4-byte immediate, or a 2-byte immediate when a 0x66 prefix is present. Opcodes 0x88 to 0x8B carry no immediate. All six opcodes take a ModR/M byte.
- R6: The ModR/M byte is reported as three fields: mod_o from bits 7:6, reg_o from bits 5:3 and rm_o from bits 2:0. has_modrm_o is high when a ModR/M byte was present. When mod is 11b, no SIB byte and no displacement follow.
- R7: With 32/64-bit addressing, a SIB byte follows when mod is not 11b and rm is 100b. A 4-byte displacement follows in three cases: when mod is 10b, when mod is 00b and rm is 101b, or when mod is 00b, a SIB is present and SIB bits 2:0 are 101b. A 1-byte displacement follows when mod is 01b.
- R8: With 0x67 present and mode64_i low, 16-bit addressing applies and no SIB byte is read. A 1-byte displacement follows when mod is 01b. A 2-byte displacement follows when mod is 10b, or when mod is 00b and rm is 110b.
- R9: With mode64_i high, 0x67 keeps the R7 rules, so a SIB byte is still read.
- R10: done_o is high only in the cycle of an instruction's final valid byte, and len_o then gives the total byte count. Cycles with byte_valid_i low do not advance the parser. The next valid byte starts a new instruction with all flags cleared.
- R11: An opcode not found in the table sets err_o and done_o on the opcode byte itself, with len_o equal to the number of prefixes plus 1.
- R12: If a valid byte arrives as byte MAX_LEN (default 15) and is not the natural last byte, the instruction ends with err_o and done_o high and len_o equal to MAX_LEN.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode64_i | input | 1 | 64-bit operating mode |
| byte_valid_i | input | 1 | byte_i holds an instruction byte this cycle |
| byte_i | input | 8 | Instruction byte |
| done_o | output | 1 | Final byte of the instruction in this cycle |
| err_o | output | 1 | Unsupported opcode or length limit reached (valid with done_o) |
| len_o | output | LEN_W | Instruction length in bytes (valid with done_o) |
| op16_o | output | 1 | Operand size override seen |
| addr_ovr_o | output | 1 | Address size override seen |
| lock_o | output | 1 | Lock prefix seen |
| rep_o | output | 1 | 0xF3 prefix seen |
| repne_o | output | 1 | 0xF2 prefix seen |
| seg_o | output | 3 | Segment override code (0 means none) |
| has_modrm_o | output | 1 | A ModR/M byte was present |
| mod_o | output | 2 | ModR/M mod field |
| reg_o | output | 3 | ModR/M reg field or opcode extension |
| rm_o | output | 3 | ModR/M r/m field |

## Verification
A wrong internal state almost always shows up as a misplaced done strobe. A missed SIB byte, a displacement counter set to the wrong size, or a stale operand-size flag moves done_o forward or back by one to four bytes. It also changes len_o in the very cycle the instruction should have ended. The bench therefore drives each addressing mode and checks that done_o is low up to the expected last byte and high on that byte. Any deviation is reported within one instruction. Flags left over from a previous instruction show up in the next instruction's done cycle, so tests run back to back.

// File: rtl/x86fp_pkg.sv
// Package: shared types for the byte-serial instruction field parser.
// Assumes: opcode table entries are packed as {code[7:0], has_modrm, imm_kind[1:0]}.
package x86fp_pkg;

    typedef enum logic [2:0] {
        ST_PREFIX = 3'd0,
        ST_MODRM  = 3'd1,
        ST_SIB    = 3'd2,
        ST_DISP   = 3'd3,
        ST_IMM    = 3'd4
    } parse_st_e;

    typedef enum logic [1:0] {
        IMM_NONE = 2'd0,
        IMM_BYTE = 2'd1,
        IMM_OPSZ = 2'd2
    } imm_kind_e;

    typedef enum logic [2:0] {
        SEG_NONE = 3'd0,
        SEG_ES   = 3'd1,
        SEG_CS   = 3'd2,
        SEG_SS   = 3'd3,
        SEG_DS   = 3'd4,
        SEG_FS   = 3'd5,
        SEG_GS   = 3'd6
    } seg_e;

    typedef struct packed {
        logic lock;
        logic repne;
        logic rep;
        logic op16;
        logic adr;
        seg_e seg;
    } pfx_flags_t;

    localparam int OP_ENTRY_W = 11;

    function automatic logic [OP_ENTRY_W-1:0] op_entry(input logic [7:0] code,
                                                       input logic modrm,
                                                       input imm_kind_e kind);
        return {code, modrm, kind};
    endfunction

    localparam int DEF_NUM_OPS = 6;
    localparam logic [DEF_NUM_OPS*OP_ENTRY_W-1:0] DEF_OP_TABLE = {
        op_entry(8'h8B, 1'b1, IMM_NONE),
        op_entry(8'h8A, 1'b1, IMM_NONE),
        op_entry(8'h89, 1'b1, IMM_NONE),
        op_entry(8'h88, 1'b1, IMM_NONE),
        op_entry(8'hC7, 1'b1, IMM_OPSZ),
        op_entry(8'hC6, 1'b1, IMM_BYTE)
    };

endpackage

// File: rtl/x86fp_prefix_dec.sv
// Module: prefix classifier. Decides whether a byte is a legacy prefix and
// gives the flag set that results from applying it to the current flags.
// Assumes: called only while the parser sits in the prefix state.
module x86fp_prefix_dec
    import x86fp_pkg::*;
(
    input  logic [7:0]  byte_i,
    input  logic        mode64_i,
    input  pfx_flags_t  cur_i,
    output logic        is_pfx_o,
    output pfx_flags_t  nxt_o
);

    // Classify the byte and merge its effect into the flag set.
    always_comb begin
        nxt_o    = cur_i;
        is_pfx_o = 1'b1;
        case (byte_i)
            8'h66: nxt_o.op16  = 1'b1;
            8'h67: nxt_o.adr   = 1'b1;
            8'hF0: nxt_o.lock  = 1'b1;
            8'hF2: nxt_o.repne = 1'b1;
            8'hF3: nxt_o.rep   = 1'b1;
            8'h26: if (!mode64_i) nxt_o.seg = SEG_ES;
            8'h2E: if (!mode64_i) nxt_o.seg = SEG_CS;
            8'h36: if (!mode64_i) nxt_o.seg = SEG_SS;
            8'h3E: if (!mode64_i) nxt_o.seg = SEG_DS;
            8'h64: nxt_o.seg = SEG_FS;
            8'h65: nxt_o.seg = SEG_GS;
            default: is_pfx_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/x86fp_op_lookup.sv
// Module: opcode table lookup. Matches a byte against every table entry and
// returns whether it is supported, whether a ModR/M byte follows, and the
// immediate kind. The lowest-index matching entry wins.
// Assumes: entries packed as in x86fp_pkg::op_entry.
module x86fp_op_lookup
    import x86fp_pkg::*;
#(
    parameter int NUM_OPS = DEF_NUM_OPS,
    parameter logic [NUM_OPS*OP_ENTRY_W-1:0] OP_TABLE = DEF_OP_TABLE
) (
    input  logic [7:0] byte_i,
    output logic       hit_o,
    output logic       has_modrm_o,
    output imm_kind_e  imm_kind_o
);

    logic [NUM_OPS-1:0] match;

    // One comparator per table entry.
    for (genvar i = 0; i < NUM_OPS; i++) begin : g_ent
        assign match[i] = (OP_TABLE[i*OP_ENTRY_W+3 +: 8] == byte_i);
    end

    // Select the attributes of the winning entry.
    always_comb begin
        hit_o       = |match;
        has_modrm_o = 1'b0;
        imm_kind_o  = IMM_NONE;
        for (int i = NUM_OPS-1; i >= 0; i--) begin
            if (match[i]) begin
                has_modrm_o = OP_TABLE[i*OP_ENTRY_W+2];
                imm_kind_o  = imm_kind_e'(OP_TABLE[i*OP_ENTRY_W +: 2]);
            end
        end
    end

endmodule

// File: rtl/x86fp_addr_len.sv
// Module: addressing-mode sizer. From mod, rm, the SIB base and the address
// width, decides whether a SIB byte follows and how many displacement bytes.
// Assumes: sib_seen_i is high only when base_i holds a real SIB base field.
module x86fp_addr_len (
    input  logic [1:0] mod_i,
    input  logic [2:0] rm_i,
    input  logic [2:0] base_i,
    input  logic       sib_seen_i,
    input  logic       addr16_i,
    output logic       need_sib_o,
    output logic [3:0] disp_len_o
);

    // SIB presence: only with 32/64-bit addressing and a memory rm of 100b.
    always_comb begin
        need_sib_o = !addr16_i && !sib_seen_i && (mod_i != 2'b11) && (rm_i == 3'b100);
    end

    // Displacement size for the two address widths.
    always_comb begin
        disp_len_o = 4'd0;
        if (addr16_i) begin
            case (mod_i)
                2'b01:   disp_len_o = 4'd1;
                2'b10:   disp_len_o = 4'd2;
                2'b00:   disp_len_o = (rm_i == 3'b110) ? 4'd2 : 4'd0;
                default: disp_len_o = 4'd0;
            endcase
        end else begin
            case (mod_i)
                2'b01:   disp_len_o = 4'd1;
                2'b10:   disp_len_o = 4'd4;
                2'b00:   disp_len_o = ((!sib_seen_i && rm_i == 3'b101) ||
                                       (sib_seen_i && base_i == 3'b101)) ? 4'd4 : 4'd0;
                default: disp_len_o = 4'd0;
            endcase
        end
    end

endmodule

// File: rtl/x86_field_parser.sv
// Module: byte-serial instruction field parser (top). Walks prefixes, opcode,
// ModR/M, SIB, displacement and immediate, one valid byte per cycle, and
// strobes done_o combinationally on the last byte with the decoded fields.
// Assumes: mode64_i is steady within an instruction; outputs other than
// done_o are meaningful only in the done_o cycle.
module x86_field_parser
    import x86fp_pkg::*;
#(
    parameter int MAX_LEN = 15,
    parameter int NUM_OPS = DEF_NUM_OPS,
    parameter logic [NUM_OPS*OP_ENTRY_W-1:0] OP_TABLE = DEF_OP_TABLE,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode64_i,
    input  logic             byte_valid_i,
    input  logic [7:0]       byte_i,
    output logic             done_o,
    output logic             err_o,
    output logic [LEN_W-1:0] len_o,
    output logic             op16_o,
    output logic             addr_ovr_o,
    output logic             lock_o,
    output logic             rep_o,
    output logic             repne_o,
    output logic [2:0]       seg_o,
    output logic             has_modrm_o,
    output logic [1:0]       mod_o,
    output logic [2:0]       reg_o,
    output logic [2:0]       rm_o
);

    localparam logic [LEN_W-1:0] LAST_CNT = LEN_W'(MAX_LEN - 1);

    parse_st_e        st_q, st_d;
    logic [LEN_W-1:0] cnt_q, cnt_d;
    pfx_flags_t       flags_q, flags_d;
    logic [7:0]       modrm_q, modrm_d;
    logic             modrm_seen_q, modrm_seen_d;
    logic [3:0]       imm_q, imm_d;
    logic [3:0]       rem_q, rem_d;

    logic             is_pfx;
    pfx_flags_t       pfx_nxt;
    logic             op_hit, op_modrm;
    imm_kind_e        op_kind;
    logic [3:0]       op_imm_len;
    logic             in_modrm, in_sib, addr16;
    logic [1:0]       a_mod;
    logic [2:0]       a_rm;
    logic             need_sib;
    logic [3:0]       disp_len;
    logic             nat_done, nat_err, over;

    x86fp_prefix_dec u_pfx (
        .byte_i   (byte_i),
        .mode64_i (mode64_i),
        .cur_i    (flags_q),
        .is_pfx_o (is_pfx),
        .nxt_o    (pfx_nxt)
    );

    x86fp_op_lookup #(.NUM_OPS(NUM_OPS), .OP_TABLE(OP_TABLE)) u_ops (
        .byte_i      (byte_i),
        .hit_o       (op_hit),
        .has_modrm_o (op_modrm),
        .imm_kind_o  (op_kind)
    );

    // Address operands come from the live byte in ModR/M state, else the stored one.
    always_comb begin
        in_modrm = (st_q == ST_MODRM);
        in_sib   = (st_q == ST_SIB);
        addr16   = flags_q.adr && !mode64_i;
        a_mod    = in_modrm ? byte_i[7:6] : modrm_q[7:6];
        a_rm     = in_modrm ? byte_i[2:0] : modrm_q[2:0];
    end

    x86fp_addr_len u_addr (
        .mod_i      (a_mod),
        .rm_i       (a_rm),
        .base_i     (byte_i[2:0]),
        .sib_seen_i (in_sib),
        .addr16_i   (addr16),
        .need_sib_o (need_sib),
        .disp_len_o (disp_len)
    );

    // Immediate size of the opcode under the current operand size.
    always_comb begin
        case (op_kind)
            IMM_BYTE: op_imm_len = 4'd1;
            IMM_OPSZ: op_imm_len = flags_q.op16 ? 4'd2 : 4'd4;
            default:  op_imm_len = 4'd0;
        endcase
    end

    // Next-state logic of the field walk.
    always_comb begin
        st_d         = st_q;
        cnt_d        = cnt_q;
        flags_d      = flags_q;
        modrm_d      = modrm_q;
        modrm_seen_d = modrm_seen_q;
        imm_d        = imm_q;
        rem_d        = rem_q;
        nat_done     = 1'b0;
        nat_err      = 1'b0;
        if (byte_valid_i) begin
            cnt_d = cnt_q + 1'b1;
            case (st_q)
                ST_PREFIX: begin
                    if (is_pfx) begin
                        flags_d = pfx_nxt;
                    end else if (!op_hit) begin
                        nat_done = 1'b1;
                        nat_err  = 1'b1;
                    end else begin
                        imm_d = op_imm_len;
                        if (op_modrm) begin
                            st_d = ST_MODRM;
                        end else if (op_imm_len != 4'd0) begin
                            st_d  = ST_IMM;
                            rem_d = op_imm_len;
                        end else begin
                            nat_done = 1'b1;
                        end
                    end
                end
                ST_MODRM, ST_SIB: begin
                    if (in_modrm) begin
                        modrm_d      = byte_i;
                        modrm_seen_d = 1'b1;
                    end
                    if (need_sib) begin
                        st_d = ST_SIB;
                    end else if (disp_len != 4'd0) begin
                        st_d  = ST_DISP;
                        rem_d = disp_len;
                    end else if (imm_q != 4'd0) begin
                        st_d  = ST_IMM;
                        rem_d = imm_q;
                    end else begin
                        nat_done = 1'b1;
                    end
                end
                ST_DISP: begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == 4'd1) begin
                        if (imm_q != 4'd0) begin
                            st_d  = ST_IMM;
                            rem_d = imm_q;
                        end else begin
                            nat_done = 1'b1;
                        end
                    end
                end
                ST_IMM: begin
                    rem_d = rem_q - 1'b1;
                    if (rem_q == 4'd1) nat_done = 1'b1;
                end
                default: st_d = ST_PREFIX;
            endcase
        end
        over = byte_valid_i && !nat_done && (cnt_q == LAST_CNT);
        if (nat_done || over) begin
            st_d         = ST_PREFIX;
            cnt_d        = '0;
            flags_d      = '0;
            modrm_seen_d = 1'b0;
            rem_d        = 4'd0;
            imm_d        = 4'd0;
        end
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q         <= ST_PREFIX;
            cnt_q        <= '0;
            flags_q      <= '0;
            modrm_q      <= 8'd0;
            modrm_seen_q <= 1'b0;
            imm_q        <= 4'd0;
            rem_q        <= 4'd0;
        end else begin
            st_q         <= st_d;
            cnt_q        <= cnt_d;
            flags_q      <= flags_d;
            modrm_q      <= modrm_d;
            modrm_seen_q <= modrm_seen_d;
            imm_q        <= imm_d;
            rem_q        <= rem_d;
        end
    end

    // Port view of the decoded instruction.
    always_comb begin
        done_o      = nat_done || over;
        err_o       = nat_err || over;
        len_o       = cnt_q + 1'b1;
        op16_o      = flags_q.op16;
        addr_ovr_o  = flags_q.adr;
        lock_o      = flags_q.lock;
        rep_o       = flags_q.rep;
        repne_o     = flags_q.repne;
        seg_o       = flags_q.seg;
        has_modrm_o = modrm_seen_q || in_modrm;
        mod_o       = in_modrm ? byte_i[7:6] : modrm_q[7:6];
        reg_o       = in_modrm ? byte_i[5:3] : modrm_q[5:3];
        rm_o        = in_modrm ? byte_i[2:0] : modrm_q[2:0];
    end

    // R10
    done_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> byte_valid_i);

    // R11
    err_implies_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    // R12
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (len_o >= 1 && len_o <= LEN_W'(MAX_LEN)));

    // R10
    after_done_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (st_q == ST_PREFIX && cnt_q == '0 && flags_q == '0));

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> ($stable(st_q) && $stable(cnt_q)));

    // R6
    reg_mode_no_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MODRM && byte_valid_i && byte_i[7:6] == 2'b11)
        |=> (st_q == ST_IMM || st_q == ST_PREFIX));

    // R8
    no_sib16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_MODRM && byte_valid_i && flags_q.adr && !mode64_i)
        |=> (st_q != ST_SIB));

    // R4
    seg64_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PREFIX && byte_valid_i && mode64_i && !done_o &&
         (byte_i == 8'h26 || byte_i == 8'h2E || byte_i == 8'h36 || byte_i == 8'h3E))
        |=> (flags_q.seg == $past(flags_q.seg)));

    // R7
    rem_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DISP || st_q == ST_IMM) |-> (rem_q != 4'd0));

endmodule

// File: tb/x86_field_parser_tb_top.sv
// Bench: directed scenarios, one task each, checking the parser at its ports.
module x86_field_parser_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_LEN    = 15;
    localparam int LEN_W      = $clog2(MAX_LEN + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             mode64 = 1'b0;
    logic             bvalid = 1'b0;
    logic [7:0]       bdata = 8'h00;
    logic             done, err, op16, adr, lock, rep, repne, has_modrm;
    logic [LEN_W-1:0] len;
    logic [2:0]       seg, reg_f, rm_f;
    logic [1:0]       mod_f;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    logic [7:0] ibuf [0:31];
    int         nidx;
    logic       early_done;
    logic       g_done, g_err, g_op16, g_adr, g_lock, g_rep, g_repne, g_modrm;
    int         g_len, g_seg, g_mod, g_reg, g_rm;

    always #(CLK_PERIOD/2) clk = ~clk;

    x86_field_parser #(.MAX_LEN(MAX_LEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode64_i(mode64),
        .byte_valid_i(bvalid), .byte_i(bdata),
        .done_o(done), .err_o(err), .len_o(len),
        .op16_o(op16), .addr_ovr_o(adr), .lock_o(lock),
        .rep_o(rep), .repne_o(repne), .seg_o(seg),
        .has_modrm_o(has_modrm), .mod_o(mod_f), .reg_o(reg_f), .rm_o(rm_f)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr();
        nidx = 0;
    endtask

    task automatic ld(input logic [7:0] b);
        ibuf[nidx] = b;
        nidx++;
    endtask

    task automatic ld_n(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) ld(b);
    endtask

    // Drive the loaded bytes back to back; capture outputs on the last one.
    task automatic feed();
        early_done = 1'b0;
        for (int i = 0; i < nidx; i++) begin
            @(negedge clk);
            bvalid = 1'b1;
            bdata  = ibuf[i];
            #1;
            if (i < nidx - 1 && done) early_done = 1'b1;
            if (i == nidx - 1) begin
                g_done = done; g_err = err; g_len = int'(len);
                g_op16 = op16; g_adr = adr; g_lock = lock; g_rep = rep; g_repne = repne;
                g_seg = int'(seg); g_modrm = has_modrm;
                g_mod = int'(mod_f); g_reg = int'(reg_f); g_rm = int'(rm_f);
            end
        end
        @(negedge clk);
        bvalid = 1'b0;
    endtask

    task automatic go(input int exp_len, input bit exp_err, input string req);
        feed();
        check(!early_done, {req, " no early done"}, int'(early_done), 0);
        check(g_done == 1'b1, {req, " done on last byte"}, int'(g_done), 1);
        check(g_len == exp_len, {req, " length"}, g_len, exp_len);
        check(g_err == exp_err, {req, " err"}, int'(g_err), int'(exp_err));
    endtask

    task automatic t_reset();
        #1;
        check(done == 1'b0, "R1 done after reset", int'(done), 0);
        check(err == 1'b0, "R1 err after reset", int'(err), 0);
        check({op16, adr, lock, rep, repne} == 5'b0, "R1 flags after reset",
              int'({op16, adr, lock, rep, repne}), 0);
        check(seg == 3'd0, "R1 seg after reset", int'(seg), 0);
    endtask

    task automatic t_opcodes();
        clr(); ld(8'hC6); ld(8'h00); ld(8'h05);
        go(3, 1'b0, "R5 C6 imm8");
        check(g_mod == 0 && g_reg == 0 && g_rm == 0, "R6 fields C6", g_mod, 0);
        clr(); ld(8'hC7); ld(8'h03); ld_n(8'h11, 4);
        go(6, 1'b0, "R5 C7 imm32");
        check(g_rm == 3, "R6 rm C7", g_rm, 3);
        clr(); ld(8'h66); ld(8'hC7); ld(8'h03); ld_n(8'h22, 2);
        go(5, 1'b0, "R5 C7 imm16");
        check(g_op16 == 1'b1, "R2 op16", int'(g_op16), 1);
    endtask

    task automatic t_regreg();
        clr(); ld(8'h89); ld(8'hC8);
        go(2, 1'b0, "R6 reg-reg");
        check(g_mod == 3 && g_reg == 1 && g_rm == 0, "R6 fields C8", g_reg, 1);
        check(g_modrm == 1'b1, "R6 has_modrm", int'(g_modrm), 1);
        clr(); ld(8'hC7); ld(8'hC4); ld_n(8'h33, 4);
        go(6, 1'b0, "R6 mod11 rm100 no SIB");
    endtask

    task automatic t_addr32();
        clr(); ld(8'h8B); ld(8'h04); ld(8'h88);
        go(3, 1'b0, "R7 SIB no disp");
        clr(); ld(8'h8B); ld(8'h04); ld(8'h25); ld_n(8'h44, 4);
        go(7, 1'b0, "R7 SIB base101 disp32");
        clr(); ld(8'h8B); ld(8'h44); ld(8'h24); ld(8'h08);
        go(4, 1'b0, "R7 SIB disp8");
        clr(); ld(8'h8B); ld(8'h84); ld(8'h24); ld_n(8'h55, 4);
        go(7, 1'b0, "R7 SIB mod10 disp32");
        clr(); ld(8'h8B); ld(8'h05); ld_n(8'h66, 4);
        go(6, 1'b0, "R7 mod00 rm101 disp32");
        clr(); ld(8'hC6); ld(8'h80); ld_n(8'h01, 4); ld(8'h7F);
        go(7, 1'b0, "R7 mod10 disp32 plus imm8");
    endtask

    task automatic t_addr16();
        clr(); ld(8'h67); ld(8'h8B); ld(8'h06); ld_n(8'h12, 2);
        go(5, 1'b0, "R8 mod00 rm110 disp16");
        check(g_adr == 1'b1, "R2 addr override", int'(g_adr), 1);
        clr(); ld(8'h67); ld(8'h8B); ld(8'h46); ld(8'h08);
        go(4, 1'b0, "R8 disp8");
        clr(); ld(8'h67); ld(8'h8B); ld(8'h04);
        go(3, 1'b0, "R8 rm100 no SIB");
        clr(); ld(8'h67); ld(8'h8B); ld(8'h84); ld_n(8'h21, 2);
        go(5, 1'b0, "R8 mod10 disp16");
    endtask

    task automatic t_mode64();
        mode64 = 1'b1;
        clr(); ld(8'h67); ld(8'h8B); ld(8'h04); ld(8'h24);
        go(4, 1'b0, "R9 67 in 64-bit keeps SIB");
        clr(); ld(8'h2E); ld(8'h8B); ld(8'h00);
        go(3, 1'b0, "R4 CS prefix counted");
        check(g_seg == 0, "R4 CS ignored", g_seg, 0);
        clr(); ld(8'h64); ld(8'h3E); ld(8'h8B); ld(8'h00);
        go(4, 1'b0, "R4 FS then DS");
        check(g_seg == 5, "R4 FS kept over DS", g_seg, 5);
        mode64 = 1'b0;
        clr(); ld(8'h2E); ld(8'h8B); ld(8'h00);
        go(3, 1'b0, "R3 CS 32-bit");
        check(g_seg == 2, "R3 CS code", g_seg, 2);
        clr(); ld(8'h26); ld(8'h65); ld(8'h8B); ld(8'h00);
        go(4, 1'b0, "R3 last segment wins");
        check(g_seg == 6, "R3 GS code", g_seg, 6);
    endtask

    task automatic t_prefixes();
        clr(); ld(8'hF0); ld(8'hF3); ld(8'hF2); ld(8'h66); ld(8'hC6); ld(8'h00); ld(8'h07);
        go(7, 1'b0, "R2 four prefixes C6 imm8");
        check(g_lock && g_rep && g_repne && g_op16, "R2 lock/rep/repne/op16",
              int'({g_lock, g_rep, g_repne, g_op16}), 15);
    endtask

    task automatic t_error();
        clr(); ld(8'h66); ld(8'h0F);
        go(2, 1'b1, "R11 unsupported opcode");
        clr(); ld(8'h89); ld(8'hC8);
        go(2, 1'b0, "R10 next instruction");
        check(g_op16 == 1'b0, "R10 flags cleared", int'(g_op16), 0);
    endtask

    task automatic t_gap();
        @(negedge clk); bvalid = 1'b1; bdata = 8'hC6; #1;
        check(done == 1'b0, "R10 gap byte0", int'(done), 0);
        @(negedge clk); bdata = 8'h00; #1;
        @(negedge clk); bvalid = 1'b0; bdata = 8'hC6; #1;
        check(done == 1'b0, "R10 idle cycle", int'(done), 0);
        @(negedge clk); #1;
        @(negedge clk); bvalid = 1'b1; bdata = 8'h09; #1;
        check(done == 1'b1 && len == 3, "R10 done after gap", int'(len), 3);
        @(negedge clk); bvalid = 1'b0;
    endtask

    task automatic t_overflow();
        clr(); ld_n(8'h66, 15);
        go(MAX_LEN, 1'b1, "R12 prefix overflow");
        clr(); ld_n(8'hF0, 10); ld(8'hC7); ld(8'h04); ld(8'h25); ld_n(8'h00, 2);
        go(MAX_LEN, 1'b1, "R12 long instruction");
        clr(); ld(8'h88); ld(8'hD1);
        go(2, 1'b0, "R12 recovery");
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_opcodes();
        t_regreg();
        t_addr32();
        t_addr16();
        t_mode64();
        t_prefixes();
        t_error();
        t_gap();
        t_overflow();
        repeat (2) @(negedge clk);
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
    end

endmodule